// File: doc/BRIEF.md
# Halfword-Swapping DMA Address and Data Adapter

This block connects a peripheral with a 16-bit data path to a memory port that has 32-bit beats. A request names a channel style, a direction, a byte offset and a byte length. The block then runs the whole transfer one beat at a time over a valid/ready memory handshake. Each beat moves either one halfword or one byte, with byte strobes that pick the lanes inside the 32-bit word.

There are two channel styles. A network transfer forms its memory address by OR-ing the peripheral's offset into a base word that is held outside the block. Unless bypass is requested, a network transfer also drops bit 0 of both the address and the length. It then moves whole halfwords and exchanges the two bytes of each one. A storage transfer ignores the offset and the bypass flag and starts at an internal address register, which can be loaded. When the transfer completes, that register advances by the transfer length. Swapped memory writes are marked off into bursts of at most 64 bytes.

Top module: `hwswap_dma_adapter`

## Requirements
- R1: A network transfer starts at the byte address `reqOffset | baseWord`, a bitwise OR and not a sum.
- R2: A network transfer with `reqBypass`=1 and every storage transfer keep the address and length unchanged. They move one byte per beat, with no swap. The byte travels in `pWrData[7:0]` or `pRdData[7:0]`, with `pRdData[15:8]`=0. The strobe is one-hot on lane address[1:0].
- R3: A network transfer with `reqBypass`=0 clears bit 0 of the start address and bit 0 of the length before it issues any beat.
- R4: A swapped transfer moves one halfword per beat on the lanes chosen by address bit 1 (`memStrb`=0011 when bit 1 is 0, 1100 when it is 1). The lower-addressed memory byte holds `pWrData[15:8]` and the upper one holds `pWrData[7:0]`. A read returns the selected memory halfword with its bytes exchanged. Strobe lanes that are not enabled carry zero.
- R5: During a swapped write, `memLast` marks the final beat of every 64 bytes counted from the transfer start, and also the final beat of the transfer. The address keeps advancing across these boundaries. Any other transfer asserts `memLast` only on its final beat.
- R6: A storage transfer starts at `storAddr`. In the cycle that `done` is high, `storAddr` has already advanced by the transfer length. `addrLoad` loads `storAddr` from `addrLoadVal`. Nothing else changes it.
- R7: A request whose length is zero after truncation issues no memory beat. It raises `done` in the cycle after it is accepted.
- R8: `done` is high for exactly one cycle. That cycle follows the acceptance of the last beat.
- R9: After reset, `reqReady`=1, `memValid`=0, `done`=0 and `storAddr`=0.
- R10: While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `memLast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request valid |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqChanStor | input | 1 | 1 = storage channel, 0 = network channel |
| reqWrite | input | 1 | 1 = write memory, 0 = read memory |
| reqBypass | input | 1 | Network only: 1 = move bytes unchanged |
| reqOffset | input | 32 | Network byte offset |
| reqLen | input | 16 | Transfer length in bytes |
| baseWord | input | 32 | Upper-address word merged into network addresses |
| addrLoad | input | 1 | Load strobe for the storage address |
| addrLoadVal | input | 32 | Value loaded into the storage address |
| storAddr | output | 32 | Current storage address |
| pWrData | input | 16 | Peripheral write data for the current beat |
| pDataAck | output | 1 | Current beat accepted by memory |
| pRdData | output | 16 | Peripheral read data |
| pRdValid | output | 1 | pRdData valid (one cycle per read beat) |
| memValid | output | 1 | Memory beat valid |
| memReady | input | 1 | Memory beat accepted |
| memAddr | output | 32 | Word-aligned memory address |
| memStrb | output | 4 | Byte-lane strobes |
| memWrData | output | 32 | Memory write data |
| memWrite | output | 1 | Beat direction, 1 = write |
| memRdData | input | 32 | Memory read data, valid with memReady |
| memLast | output | 1 | Last beat of a burst |
| done | output | 1 | Transfer complete pulse |

## Verification
The in-RTL properties watch, on every cycle, the strobe shapes in halfword mode and in byte mode, and the evenness of swapped addresses. They also cover beat stability under back-pressure, the single-cycle `done`, the rule that the storage address changes only at completion or load, and the absence of memory beats while a request can be taken. Other properties are only visible in the bench's scenarios. These are the OR merge against an additive merge, the exact byte exchange on write and read data, and the placement of burst boundaries in a 130-byte transfer. The bench also shows the storage address advancing across back-to-back transfers and the zero-length shortcut.

// File: rtl/hwswap_pkg.sv
package hwswap_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xferState_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic       beatValid;
    logic       beatFire;
    logic       halfMode;
    logic [1:0] laneSel;
    logic       isWrite;
  } dpStrobe_t;

endpackage

// File: rtl/hwswap_ctrl.sv
module hwswap_ctrl
  import hwswap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqChanStor,
  input  logic              reqWrite,
  input  logic              reqBypass,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] baseWord,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrLoadVal,
  output logic [ADDR_W-1:0] storAddr,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic              memLast,
  output logic              done,
  output dpStrobe_t         strobe
);

  localparam int CHUNK_W = $clog2(CHUNK_BYTES) + 1;

  xferState_e        state;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] storAddrQ;
  logic [ADDR_W-1:0] mergedAddr;
  logic [ADDR_W-1:0] startAddr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  totalLen;
  logic [LEN_W-1:0]  startLen;
  logic [LEN_W-1:0]  stepLen;
  logic [CHUNK_W-1:0] chunkCnt;
  logic [CHUNK_W-1:0] stepChunk;
  logic [CHUNK_W-1:0] chunkNext;
  logic swapQ, writeQ, storQ, doneQ;
  logic useSwap, accept, fire, lastBeat, chunkEnd;

  // Start address and length for an incoming request
  always_comb begin
    mergedAddr = reqChanStor ? storAddrQ : (reqOffset | baseWord);
    useSwap    = !reqChanStor && !reqBypass;
    startAddr  = useSwap ? {mergedAddr[ADDR_W-1:1], 1'b0} : mergedAddr;
    startLen   = useSwap ? {reqLen[LEN_W-1:1], 1'b0} : reqLen;
  end

  assign reqReady = (state == ST_IDLE) && !doneQ;
  assign accept   = reqValid && reqReady;
  assign memValid = (state == ST_RUN);
  assign fire     = memValid && memReady;

  // Beat sizing and burst boundaries
  always_comb begin
    stepLen   = swapQ ? LEN_W'(2) : LEN_W'(1);
    stepChunk = swapQ ? CHUNK_W'(2) : CHUNK_W'(1);
    chunkNext = chunkCnt + stepChunk;
    lastBeat  = (remain == stepLen);
    chunkEnd  = swapQ && writeQ && (chunkNext == CHUNK_W'(CHUNK_BYTES));
  end

  assign memLast  = memValid && (lastBeat || chunkEnd);
  assign memAddr  = {curAddr[ADDR_W-1:2], 2'b00};
  assign memWrite = writeQ;
  assign done     = doneQ;
  assign storAddr = storAddrQ;

  assign strobe.beatValid = memValid;
  assign strobe.beatFire  = fire;
  assign strobe.halfMode  = swapQ;
  assign strobe.laneSel   = curAddr[1:0];
  assign strobe.isWrite   = writeQ;

  // Transfer sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curAddr  <= '0;
      remain   <= '0;
      totalLen <= '0;
      chunkCnt <= '0;
      swapQ    <= 1'b0;
      writeQ   <= 1'b0;
      storQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        swapQ    <= useSwap;
        writeQ   <= reqWrite;
        storQ    <= reqChanStor;
        curAddr  <= startAddr;
        remain   <= startLen;
        totalLen <= startLen;
        chunkCnt <= '0;
        if (startLen == '0) begin
          doneQ <= 1'b1;
        end else begin
          state <= ST_RUN;
        end
      end
      if (fire) begin
        curAddr  <= curAddr + ADDR_W'(stepLen);
        remain   <= remain - stepLen;
        chunkCnt <= chunkEnd ? '0 : chunkNext;
        if (lastBeat) begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
      end
    end
  end

  // Storage address register: load wins over completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      storAddrQ <= '0;
    end else if (addrLoad) begin
      storAddrQ <= addrLoadVal;
    end else if (fire && lastBeat && storQ) begin
      storAddrQ <= storAddrQ + ADDR_W'(totalLen);
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memLast)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_STOR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !addrLoad |=> ($stable(storAddr) || done)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memValid); // R7
  AST_EVEN_HALF: assert property (@(posedge clk) disable iff (!rstN)
    memValid && swapQ |-> !curAddr[0]); // R3

endmodule

// File: rtl/hwswap_datapath.sv
module hwswap_datapath
  import hwswap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [15:0]       pWrData,
  output logic              pDataAck,
  output logic [15:0]       pRdData,
  output logic              pRdValid,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W/8-1:0] memStrb,
  input  logic [DATA_W-1:0] memRdData
);

  localparam int LANES = DATA_W / 8;

  logic [15:0] rdHalf;
  logic [7:0]  rdByte;
  logic [15:0] rdNext;

  // Write lanes: halfword mode swaps bytes, byte mode places one byte
  for (genvar i = 0; i < LANES; i++) begin : gLane
    localparam logic [1:0] LIDX = 2'(i);
    logic laneOn;
    logic [7:0] laneByte;
    assign laneOn = strobe.beatValid &&
                    (strobe.halfMode ? (strobe.laneSel[1] == LIDX[1])
                                     : (strobe.laneSel == LIDX));
    assign laneByte = !strobe.halfMode ? pWrData[7:0]
                    : (LIDX[0] ? pWrData[7:0] : pWrData[15:8]);
    assign memStrb[i]          = laneOn;
    assign memWrData[8*i +: 8] = laneOn ? laneByte : 8'h00;
  end

  // Read path
  always_comb begin
    rdHalf = strobe.laneSel[1] ? memRdData[31:16] : memRdData[15:0];
    case (strobe.laneSel)
      2'd0:    rdByte = memRdData[7:0];
      2'd1:    rdByte = memRdData[15:8];
      2'd2:    rdByte = memRdData[23:16];
      default: rdByte = memRdData[31:24];
    endcase
    rdNext = strobe.halfMode ? {rdHalf[7:0], rdHalf[15:8]} : {8'h00, rdByte};
  end

  assign pDataAck = strobe.beatFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pRdValid <= 1'b0;
      pRdData  <= '0;
    end else begin
      pRdValid <= strobe.beatFire && !strobe.isWrite;
      if (strobe.beatFire && !strobe.isWrite) begin
        pRdData <= rdNext;
      end
    end
  end

  AST_HALF_STRB: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatValid && strobe.halfMode |->
      ($countones(memStrb) == 2) && (memStrb[0] == memStrb[1])); // R4
  AST_BYTE_STRB: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatValid && !strobe.halfMode |-> $countones(memStrb) == 1); // R2
  AST_IDLE_STRB: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.beatValid |-> memStrb == '0); // R4

endmodule

// File: rtl/hwswap_dma_adapter.sv
module hwswap_dma_adapter
  import hwswap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqChanStor,
  input  logic              reqWrite,
  input  logic              reqBypass,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] baseWord,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrLoadVal,
  output logic [ADDR_W-1:0] storAddr,
  input  logic [15:0]       pWrData,
  output logic              pDataAck,
  output logic [15:0]       pRdData,
  output logic              pRdValid,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memStrb,
  output logic [31:0]       memWrData,
  output logic              memWrite,
  input  logic [31:0]       memRdData,
  output logic              memLast,
  output logic              done
);

  dpStrobe_t strobe;

  hwswap_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqChanStor(reqChanStor), .reqWrite(reqWrite), .reqBypass(reqBypass),
    .reqOffset(reqOffset), .reqLen(reqLen), .baseWord(baseWord),
    .addrLoad(addrLoad), .addrLoadVal(addrLoadVal), .storAddr(storAddr),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memWrite(memWrite), .memLast(memLast), .done(done), .strobe(strobe)
  );

  hwswap_datapath #(.DATA_W(32)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pWrData(pWrData), .pDataAck(pDataAck),
    .pRdData(pRdData), .pRdValid(pRdValid),
    .memWrData(memWrData), .memStrb(memStrb), .memRdData(memRdData)
  );

endmodule

// File: tb/hwswap_dma_adapter_test.sv
`timescale 1ns/1ps
module hwswap_dma_adapter_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        reqValid = 0, reqChanStor = 0, reqWrite = 0, reqBypass = 0;
  logic [31:0] reqOffset = '0;
  logic [15:0] reqLen = '0;
  logic [31:0] baseWord = 32'h4000_0000;
  logic        addrLoad = 0;
  logic [31:0] addrLoadVal = '0;
  logic [15:0] pWrData = '0;
  logic        memReady = 1'b1;
  logic        reqReady, pDataAck, pRdValid, memValid, memWrite, memLast, done;
  logic [31:0] storAddr, memAddr, memWrData, memRdData;
  logic [15:0] pRdData;
  logic [3:0]  memStrb;

  function automatic logic [31:0] rdWord(input logic [31:0] a);
    return {a[7:0] ^ 8'hF0, a[7:0] ^ 8'hC3, a[7:0] ^ 8'h5A, a[7:0] ^ 8'h0F};
  endfunction
  assign memRdData = rdWord(memAddr);

  hwswap_dma_adapter uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqChanStor(reqChanStor), .reqWrite(reqWrite), .reqBypass(reqBypass),
    .reqOffset(reqOffset), .reqLen(reqLen), .baseWord(baseWord),
    .addrLoad(addrLoad), .addrLoadVal(addrLoadVal), .storAddr(storAddr),
    .pWrData(pWrData), .pDataAck(pDataAck), .pRdData(pRdData), .pRdValid(pRdValid),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .memStrb(memStrb),
    .memWrData(memWrData), .memWrite(memWrite), .memRdData(memRdData),
    .memLast(memLast), .done(done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Results of the last transfer
  int nBeats, nLast, nRd;
  int lastIdx [4];
  logic [31:0] firstWord, b32Word, finalWord;
  logic [3:0]  firstStrb, finalStrb;
  logic [31:0] firstData;
  logic [15:0] rdVals [2];
  bit doneSeen, doneLowAfter;

  task automatic issue(input bit stor, input bit wr, input bit byp,
                       input logic [31:0] off, input logic [15:0] len);
    @(negedge clk);
    reqChanStor = stor; reqWrite = wr; reqBypass = byp;
    reqOffset = off; reqLen = len; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic collect();
    int guard = 0;
    nBeats = 0; nLast = 0; nRd = 0; doneSeen = 0;
    while (!doneSeen && guard < 3000) begin
      pWrData = 16'hB1C2 + 16'(nBeats);
      #1;
      if (pRdValid) begin
        if (nRd < 2) rdVals[nRd] = pRdData;
        nRd++;
      end
      if (done) begin
        doneSeen = 1;
      end else if (memValid && memReady) begin
        if (nBeats == 0) begin
          firstWord = memAddr; firstStrb = memStrb; firstData = memWrData;
        end
        if (nBeats == 32) b32Word = memAddr;
        finalWord = memAddr; finalStrb = memStrb;
        if (memLast) begin
          if (nLast < 4) lastIdx[nLast] = nBeats;
          nLast++;
        end
        nBeats++;
      end
      @(negedge clk);
      guard++;
    end
    #1;
    doneLowAfter = !done;
  endtask

  task automatic runXfer(input bit stor, input bit wr, input bit byp,
                         input logic [31:0] off, input logic [15:0] len);
    issue(stor, wr, byp, off, len);
    collect();
  endtask

  // {stor, wr, byp, offset[32], len[8], expWord[32], expStrb[4], expData[32]}
  localparam logic [110:0] VEC [8] = '{
    {3'b010, 32'h0000_0104, 8'd2, 32'h4000_0104, 4'b0011, 32'h0000_C2B1},
    {3'b010, 32'h0000_0106, 8'd2, 32'h4000_0104, 4'b1100, 32'hC2B1_0000},
    {3'b010, 32'h0000_0107, 8'd3, 32'h4000_0104, 4'b1100, 32'hC2B1_0000},
    {3'b011, 32'h0000_0107, 8'd1, 32'h4000_0104, 4'b1000, 32'hC200_0000},
    {3'b011, 32'h0000_0205, 8'd1, 32'h4000_0204, 4'b0010, 32'h0000_C200},
    {3'b110, 32'h0000_0000, 8'd1, 32'h0000_1004, 4'b0100, 32'h00C2_0000},
    {3'b110, 32'h0000_0000, 8'd1, 32'h0000_1004, 4'b1000, 32'hC200_0000},
    {3'b010, 32'h4000_0010, 8'd2, 32'h4000_0010, 4'b0011, 32'h0000_C2B1}
  };
  string vecTag [8] = '{"R4 vec0", "R4 vec1", "R3 vec2", "R2 vec3",
                        "R2 vec4", "R6 vec5", "R6 vec6", "R1 vec7"};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9 reset state
    check(reqReady == 1'b1, "R9 reqReady", 32'(reqReady), 32'd1);
    check(memValid == 1'b0, "R9 memValid", 32'(memValid), 32'd0);
    check(done == 1'b0, "R9 done", 32'(done), 32'd0);
    check(storAddr == 32'h0, "R9 storAddr", storAddr, 32'h0);

    // R6 load storage address
    @(negedge clk); addrLoad = 1'b1; addrLoadVal = 32'h0000_1006;
    @(negedge clk); addrLoad = 1'b0; #1;
    check(storAddr == 32'h0000_1006, "R6 load", storAddr, 32'h0000_1006);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      logic [110:0] v;
      v = VEC[i];
      runXfer(v[110], v[109], v[108], v[107:76], 16'(v[75:68]));
      check(nBeats == 1, {vecTag[i], " beats"}, 32'(nBeats), 32'd1);
      check(firstWord == v[67:36], {vecTag[i], " addr"}, firstWord, v[67:36]);
      check(firstStrb == v[35:32], {vecTag[i], " strb"}, 32'(firstStrb), 32'(v[35:32]));
      check(firstData == v[31:0], {vecTag[i], " data"}, firstData, v[31:0]);
      check(nLast == 1, {vecTag[i], " last"}, 32'(nLast), 32'd1);
      check(doneSeen && doneLowAfter, {"R8 ", vecTag[i], " done pulse"}, 32'(doneLowAfter), 32'd1);
    end
    check(storAddr == 32'h0000_1008, "R6 advanced", storAddr, 32'h0000_1008);

    // R5 long swapped write: 130 bytes -> 65 beats, bursts end at 31, 63, 64
    runXfer(0, 1, 0, 32'h0000_0300, 16'd130);
    check(nBeats == 65, "R5 beats", 32'(nBeats), 32'd65);
    check(nLast == 3, "R5 last count", 32'(nLast), 32'd3);
    check(lastIdx[0] == 31, "R5 first boundary", 32'(lastIdx[0]), 32'd31);
    check(lastIdx[1] == 63, "R5 second boundary", 32'(lastIdx[1]), 32'd63);
    check(lastIdx[2] == 64, "R5 final beat", 32'(lastIdx[2]), 32'd64);
    check(b32Word == 32'h4000_0340, "R5 address continues", b32Word, 32'h4000_0340);
    check(finalWord == 32'h4000_0380 && finalStrb == 4'b0011, "R5 final addr", finalWord, 32'h4000_0380);

    // R5 bypass write is not split
    runXfer(0, 1, 1, 32'h0000_0300, 16'd130);
    check(nBeats == 130, "R2 byte beats", 32'(nBeats), 32'd130);
    check(nLast == 1, "R5 unswapped single last", 32'(nLast), 32'd1);

    // R4 swapped read
    runXfer(0, 0, 0, 32'h0000_0402, 16'd4);
    check(nRd == 2, "R4 read beats", 32'(nRd), 32'd2);
    check(rdVals[0] == 16'hC3F0, "R4 read upper lane", 32'(rdVals[0]), 32'h0000_C3F0);
    check(rdVals[1] == 16'h0B5E, "R4 read lower lane", 32'(rdVals[1]), 32'h0000_0B5E);
    check(nLast == 1, "R5 read last", 32'(nLast), 32'd1);

    // R2 bypass read, byte lane 3
    runXfer(0, 0, 1, 32'h0000_0403, 16'd1);
    check(nRd == 1 && rdVals[0] == 16'h00F0, "R2 byte read", 32'(rdVals[0]), 32'h0000_00F0);

    // R7 zero length after truncation
    runXfer(0, 1, 0, 32'h0000_0600, 16'd1);
    check(nBeats == 0 && doneSeen, "R7 truncated to zero", 32'(nBeats), 32'd0);
    check(doneLowAfter, "R8 zero-length pulse", 32'(doneLowAfter), 32'd1);
    runXfer(1, 1, 0, 32'h0, 16'd0);
    check(nBeats == 0 && doneSeen, "R7 storage zero", 32'(nBeats), 32'd0);
    check(storAddr == 32'h0000_1008, "R6 zero length keeps address", storAddr, 32'h0000_1008);

    // R10 stall
    memReady = 1'b0;
    issue(0, 1, 0, 32'h0000_0500, 16'd4);
    #1;
    check(memValid && memAddr == 32'h4000_0500, "R10 stall start", memAddr, 32'h4000_0500);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(memValid && memAddr == 32'h4000_0500 && !memLast, "R10 held", memAddr, 32'h4000_0500);
    end
    @(negedge clk);
    memReady = 1'b1;
    collect();
    check(nBeats == 2 && doneSeen, "R10 completes", 32'(nBeats), 32'd2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule